// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block turns parallel audio samples into a serial bit stream with a framing line. Timing comes from outside: a one-cycle `bit_tick` strobe marks each bit-clock edge on which the transmit line may change, so the receiver samples on the opposite edge. Each frame is 64 bit periods long and holds two 32-bit slots (left, then right).

At run time the block selects one of two framing families. With word-select framing, the framing line is a level that tells left from right. Three alignments are available: the standard one-bit-late layout, left-aligned and right-aligned. With pulse framing, the framing line carries a one-bit pulse at the start of each frame, and the data either follows the pulse by one bit or starts with it. The sample width is programmable from 1 to 32 bits. Up to four parallel data lanes carry two to eight channels.

Samples arrive on a ready/valid port. One transfer per slot carries one 32-bit word per lane. If no word is offered when a slot begins, the block sends silence for that slot and raises an underrun pulse. Clearing `start` lets the current frame finish before the outputs go quiet.

Top module: `serial_audio_tx`

## Requirements
- R1: After reset and whenever the transmitter is idle, `sdo`, `ws`, `underrun` and `s_ready` are all low.
- R2: Registered outputs (`sdo`, `ws`, `underrun`) change only in the clock cycle after a cycle with `bit_tick` high.
- R3: With `pulse_sel`=0, a frame is 64 bit periods. `ws` holds one level for frame positions 0–31 (left slot) and the other level for positions 32–63 (right slot). The left level is 0 when `wfmt`=0 and 1 when `wfmt` is 1, 2 or 3.
- R4: With `wfmt`=0 and `pulse_sel`=0, each slot's MSB appears one bit period after the `ws` transition for that slot. The delayed last bit of the right slot is sent at position 0 of the following frame.
- R5: With `wfmt`=1 (or 3) and `pulse_sel`=0, the MSB appears on the same bit period as the `ws` transition. The remaining bits of the 32-bit slot after the sample are 0.
- R6: With `wfmt`=2 and `pulse_sel`=0, each slot starts with (32 − width) zero bits, followed by the sample MSB first, so the LSB falls on the slot's last bit.
- R7: With `pulse_sel`=1, `ws` is high for exactly frame position 0 of each frame. With `pcm_var`=0 the left slot starts one bit after the pulse; with any other `pcm_var` value it starts on the pulse bit. Slots are left-aligned, and `wfmt` has no effect.
- R8: The sample width is `width_m1`+1. Only bits [width−1:0] of each word are sent; higher bits are ignored.
- R9: Lanes 0 to `pairs_m1` are active. Lane i takes `s_data[32*i+31:32*i]`. Lanes above `pairs_m1` stay low.
- R10: `s_ready` is high only in a `bit_tick` cycle that begins a slot. A word is taken when `s_valid` and `s_ready` are both high.
- R11: If `s_valid` is low when a slot begins, every lane sends zeros for that slot, and `underrun` is high for exactly one clock cycle.
- R12: A `bit_tick` with `start` high while idle begins a frame at position 0. When `start` is low at the tick after the last bit of a frame (including the R4 delayed bit), the block returns to idle. Otherwise the current frame is completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe at each transmit bit-clock edge |
| start | input | 1 | Run request; clearing it stops at a frame end |
| pulse_sel | input | 1 | 0: word-select framing, 1: pulse framing |
| pcm_var | input | 2 | Pulse framing variant (0: data one bit late, else aligned) |
| wfmt | input | 2 | Word-select alignment (0 standard, 1 left, 2 right) |
| width_m1 | input | 5 | Sample width minus one |
| pairs_m1 | input | 2 | Active lane count minus one |
| s_valid | input | 1 | Sample word available |
| s_ready | output | 1 | Sample word taken this cycle |
| s_data | input | 128 | One 32-bit word per lane |
| sdo | output | 4 | Serial data, one bit per lane |
| ws | output | 1 | Word-select level or frame pulse |
| underrun | output | 1 | One-cycle pulse on a slot without data |

## Verification
The in-RTL assertions check on every cycle that the outputs hold still between ticks, that `s_ready` and `underrun` only follow a tick, that `underrun` lasts one cycle, and that the framing line is low while idle. The bit order, the one-bit delays, the zero padding in each alignment mode, the lane masking, and the frame-completion behaviour on stop all depend on whole sequences. Only the directed scenarios can show these, by comparing each captured bit with a stream computed from the requirements.

// File: rtl/sat_pkg.sv
package sat_pkg;

  localparam int SLOT_BITS = 32;

  localparam logic [1:0] WF_STD   = 2'd0;
  localparam logic [1:0] WF_LEFT  = 2'd1;
  localparam logic [1:0] WF_RIGHT = 2'd2;

  typedef struct packed {
    logic       pulse_sel;
    logic [1:0] pcm_var;
    logic [1:0] wfmt;
  } frame_cfg_t;

endpackage

// File: rtl/sat_frame_ctrl.sv
module sat_frame_ctrl
  import sat_pkg::*;
#(
  parameter int SLOT = SLOT_BITS
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       start,
  input  frame_cfg_t cfg,
  output logic       run_next,
  output logic       load,
  output logic       ws
);

  localparam int SW = $clog2(SLOT);
  localparam int PW = SW + 1;

  logic          run_q, run_n;
  logic [PW-1:0] pos_q, pos_n;
  logic          ws_q, ws_n;
  logic          delay;
  logic [PW-1:0] fpos;

  always_comb begin
    if (cfg.pulse_sel) delay = (cfg.pcm_var == 2'd0);
    else               delay = (cfg.wfmt == WF_STD);
  end

  always_comb begin
    run_n = run_q;
    pos_n = pos_q;
    ws_n  = ws_q;
    load  = 1'b0;
    fpos  = '0;
    if (bit_tick) begin
      if (!run_q) begin
        if (start) begin
          run_n = 1'b1;
          pos_n = delay ? '1 : '0;
        end
      end else if ((pos_q == '1) && !start) begin
        run_n = 1'b0;
        pos_n = '0;
      end else begin
        pos_n = pos_q + 1'b1;
      end
      load = run_n && (pos_n[SW-1:0] == '0);
      fpos = pos_n + PW'(delay);
      if (!run_n)             ws_n = 1'b0;
      else if (cfg.pulse_sel) ws_n = (fpos == '0);
      else                    ws_n = fpos[PW-1] ^ (cfg.wfmt != WF_STD);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pos_q <= '0;
      ws_q  <= 1'b0;
    end else if (bit_tick) begin
      run_q <= run_n;
      pos_q <= pos_n;
      ws_q  <= ws_n;
    end
  end

  assign run_next = run_n;
  assign ws       = ws_q;

  assert_idle_ws_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !ws_q);

endmodule

// File: rtl/sat_lane_shift.sv
module sat_lane_shift
  import sat_pkg::*;
#(
  parameter int SLOT = SLOT_BITS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bit_tick,
  input  logic                     run_next,
  input  logic                     load,
  input  logic                     lane_en,
  input  logic                     word_ok,
  input  logic                     right_just,
  input  logic [$clog2(SLOT)-1:0]  width_m1,
  input  logic [SLOT-1:0]          word,
  output logic                     sd
);

  localparam int SW = $clog2(SLOT);

  logic [SLOT-1:0] sh_q, sh_n;
  logic [SW-1:0]   pad;
  logic [SLOT-1:0] mask, masked, aligned;

  always_comb begin
    pad     = SW'(SLOT - 1) - width_m1;
    mask    = {SLOT{1'b1}} >> pad;
    masked  = word & mask;
    aligned = right_just ? masked : (masked << pad);
  end

  always_comb begin
    if (!run_next)  sh_n = '0;
    else if (load)  sh_n = (lane_en && word_ok) ? aligned : '0;
    else            sh_n = sh_q << 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh_q <= '0;
    else if (bit_tick) sh_q <= sh_n;
  end

  assign sd = sh_q[SLOT-1];

endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
  import sat_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SLOT  = SLOT_BITS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bit_tick,
  input  logic                    start,
  input  logic                    pulse_sel,
  input  logic [1:0]              pcm_var,
  input  logic [1:0]              wfmt,
  input  logic [$clog2(SLOT)-1:0] width_m1,
  input  logic [$clog2(LANES)-1:0] pairs_m1,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [LANES*SLOT-1:0]   s_data,
  output logic [LANES-1:0]        sdo,
  output logic                    ws,
  output logic                    underrun
);

  localparam int LW = $clog2(LANES);

  frame_cfg_t cfg;
  logic       run_next;
  logic       load;
  logic       right_just;
  logic       ur_q, ur_n;

  assign cfg.pulse_sel = pulse_sel;
  assign cfg.pcm_var   = pcm_var;
  assign cfg.wfmt      = wfmt;
  assign right_just    = !pulse_sel && (wfmt == WF_RIGHT);

  sat_frame_ctrl #(.SLOT(SLOT)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .start    (start),
    .cfg      (cfg),
    .run_next (run_next),
    .load     (load),
    .ws       (ws)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic lane_en;
    assign lane_en = (LW'(i) <= pairs_m1);
    sat_lane_shift #(.SLOT(SLOT)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_tick   (bit_tick),
      .run_next   (run_next),
      .load       (load),
      .lane_en    (lane_en),
      .word_ok    (s_valid),
      .right_just (right_just),
      .width_m1   (width_m1),
      .word       (s_data[i*SLOT +: SLOT]),
      .sd         (sdo[i])
    );
  end

  assign s_ready = load;
  assign ur_n    = load && !s_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ur_q <= 1'b0;
    else        ur_q <= ur_n;
  end

  assign underrun = ur_q;

  assert_ready_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> bit_tick);

  assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_tick) |-> ($stable(sdo) && $stable(ws)));

  assert_underrun_after_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> $past(bit_tick));

  assert_underrun_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);

endmodule

// File: tb/serial_audio_tx_tb.sv
module serial_audio_tx_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         bit_tick;
  logic         start;
  logic         pulse_sel;
  logic [1:0]   pcm_var;
  logic [1:0]   wfmt;
  logic [4:0]   width_m1;
  logic [1:0]   pairs_m1;
  logic         s_valid;
  logic         s_ready;
  logic [127:0] s_data;
  logic [3:0]   sdo;
  logic         ws;
  logic         underrun;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  int c_fmt, c_pcm, c_pulse, c_w, c_pm1, c_gap, c_d, c_idle;

  always #5 clk = ~clk;

  serial_audio_tx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .start(start),
    .pulse_sel(pulse_sel), .pcm_var(pcm_var), .wfmt(wfmt),
    .width_m1(width_m1), .pairs_m1(pairs_m1), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .sdo(sdo), .ws(ws),
    .underrun(underrun)
  );

  task automatic chk(input bit ok, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input int slot, input int lane);
    return (32'h9E3779B9 * 32'(slot * 4 + lane + 1)) ^ 32'h5A5A0F0F;
  endfunction

  function automatic bit running(input int k);
    return k < c_idle;
  endfunction

  function automatic bit exp_ready(input int k);
    return running(k) && (k - c_d >= 0) && (((k - c_d) % 32) == 0);
  endfunction

  function automatic logic exp_bit(input int k, input int lane);
    int s, b;
    logic [31:0] w;
    if (!running(k) || (k - c_d) < 0) return 1'b0;
    s = (k - c_d) / 32;
    b = (k - c_d) % 32;
    if (lane > c_pm1 || s == c_gap) return 1'b0;
    w = word_of(s, lane);
    if (!c_pulse && c_fmt == 2) return (b >= 32 - c_w) ? w[31 - b] : 1'b0;
    return (b < c_w) ? w[c_w - 1 - b] : 1'b0;
  endfunction

  function automatic logic exp_ws(input int k);
    int p;
    if (!running(k)) return 1'b0;
    p = k % 64;
    if (c_pulse) return p == 0;
    return (p >= 32) ^ (c_fmt != 0);
  endfunction

  task automatic run_case(input string tags, input int fmt, input int pcm,
                          input int pulse, input int wm1, input int pm1,
                          input int gap, input int stop_k);
    int n, ur_cnt, ur_exp;
    int rdy_bad, sdo_bad, ws_bad, hold_bad;
    logic [3:0] sdo_a, sdo_e, prev_sdo;
    logic ws_a, ws_e, prev_ws;
    int first_k;
    c_fmt = fmt; c_pcm = pcm; c_pulse = pulse; c_w = wm1 + 1;
    c_pm1 = pm1; c_gap = gap;
    c_d = pulse ? (pcm == 0) : (fmt == 0);
    c_idle = stop_k;
    while (c_idle < 1 || ((c_idle - c_d + 64) % 64) != 0) c_idle++;
    n = c_idle + 4;
    ur_cnt = 0; ur_exp = 0;
    rdy_bad = 0; sdo_bad = 0; ws_bad = 0; hold_bad = 0;
    sdo_a = '0; sdo_e = '0; ws_a = 0; ws_e = 0; first_k = -1;
    prev_sdo = '0; prev_ws = 1'b0;
    @(negedge clk);
    pulse_sel = pulse[0]; pcm_var = pcm[1:0]; wfmt = fmt[1:0];
    width_m1 = wm1[4:0]; pairs_m1 = pm1[1:0];
    for (int k = 0; k < n; k++) begin
      int slot;
      @(negedge clk);
      if (sdo !== prev_sdo || ws !== prev_ws) hold_bad++;
      if (underrun !== 1'b0) ur_cnt++;
      slot = (k - c_d >= 0) ? (k - c_d) / 32 : 0;
      for (int L = 0; L < 4; L++) s_data[L*32 +: 32] = word_of(slot, L);
      s_valid  = !(exp_ready(k) && slot == gap);
      start    = (k < stop_k);
      bit_tick = 1'b1;
      if (exp_ready(k) && slot == gap) ur_exp++;
      #1;
      if (s_ready !== exp_ready(k)) rdy_bad++;
      @(negedge clk);
      bit_tick = 1'b0;
      if (underrun === 1'b1) ur_cnt++;
      for (int L = 0; L < 4; L++) begin
        if (sdo[L] !== exp_bit(k, L)) begin
          if (sdo_bad == 0) begin
            first_k = k;
            sdo_a = sdo;
            for (int M = 0; M < 4; M++) sdo_e[M] = exp_bit(k, M);
          end
          sdo_bad++;
        end
      end
      if (ws !== exp_ws(k)) begin
        if (ws_bad == 0) begin ws_a = ws; ws_e = exp_ws(k); end
        ws_bad++;
      end
      prev_sdo = sdo;
      prev_ws  = ws;
    end
    start = 1'b0;
    s_valid = 1'b0;
    chk(sdo_bad == 0, $sformatf("%s R1 R12 sdo stream (first bad bit %0d)", tags, first_k),
        64'(sdo_a), 64'(sdo_e));
    chk(ws_bad == 0, $sformatf("%s R1 R12 ws framing", tags), 64'(ws_a), 64'(ws_e));
    chk(rdy_bad == 0, $sformatf("%s R10 s_ready timing mismatches", tags),
        64'(rdy_bad), 64'd0);
    chk(hold_bad == 0, $sformatf("%s R2 output change between ticks", tags),
        64'(hold_bad), 64'd0);
    chk(ur_cnt == ur_exp, $sformatf("%s R11 underrun pulse count", tags),
        64'(ur_cnt), 64'(ur_exp));
  endtask

  task automatic t_reset;
    chk(sdo === 4'd0, "R1 reset sdo", 64'(sdo), 64'd0);
    chk(ws === 1'b0, "R1 reset ws", 64'(ws), 64'd0);
    chk(underrun === 1'b0, "R1 reset underrun", 64'(underrun), 64'd0);
    chk(s_ready === 1'b0, "R1 reset s_ready", 64'(s_ready), 64'd0);
  endtask

  task automatic t_std_16;      run_case("R3 R4 R8 R9 std16",   0, 0, 0, 15, 1, -1, 100); endtask
  task automatic t_left_24;     run_case("R3 R5 R9 R12 left24", 1, 0, 0, 23, 3, -1, 64);  endtask
  task automatic t_right_20;    run_case("R3 R6 R8 right20",    2, 0, 0, 19, 0, -1, 70);  endtask
  task automatic t_pulse_late;  run_case("R7 R9 pulseA16",      0, 0, 1, 15, 2, -1, 40);  endtask
  task automatic t_pulse_align; run_case("R7 R8 R11 pulseB32",  2, 1, 1, 31, 3, 1, 90);   endtask
  task automatic t_std_32;      run_case("R4 R11 R12 std32",    0, 0, 0, 31, 0, 2, 130);  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bit_tick = 1'b0; start = 1'b0; pulse_sel = 1'b0;
    pcm_var = 2'd0; wfmt = 2'd0; width_m1 = 5'd15; pairs_m1 = 2'd0;
    s_valid = 1'b0; s_data = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_std_16();
    t_left_24();
    t_right_20();
    t_pulse_late();
    t_pulse_align();
    t_std_32();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule